// File: doc/BRIEF.md
# Exception Entry and Banked Register File

This block holds the sixteen-entry architectural register file of a classic 32-bit RISC core, together with the status word and the per-mode banked copies that exception handling needs. The stack pointer (R13), the link register (R14) and a saved status word are banked for each privileged mode. The fast-interrupt mode also has its own copy of R8 to R12. Storage is indexed by the current mode, so a mode change selects a different bank and moves no data.

An exception request arrives as one level bit per exception kind. While the block is idle, the arbiter picks the highest-priority unmasked request and the entry controller then runs a fixed four-state sequence: IDLE accepts the request (transition `take`), BANK saves the old status into the new mode's saved status word and rewrites the mode, mask and state bits, LINK writes the new mode's R14 with the PC plus a per-kind offset, and VEC loads the vector address into R15 and returns to IDLE, raising `entry_done` for one cycle. Outside an entry sequence, software-style ports write a register of the current mode or replace the whole status word, which is how modes are left.

Top module: `exc_bank_top`

## Requirements
- R1: After reset the status word reads 0x000001D3: mode SVC (0x13), A (bit 8), I (bit 7) and F (bit 6) set, state bit T (bit 5) clear. PC is 0, `busy` and `entry_done` are low, and the SVC saved status reads 0.
- R2: The mode field is bits [4:0]: USR 0x10, FIQ 0x11, IRQ 0x12, SVC 0x13, ABT 0x17, UND 0x1B, SYS 0x1F. USR and SYS share one R13/R14. SVC, ABT, UND, IRQ and FIQ each have their own R13, R14 and saved status word. R0 to R7 and R15 are shared by all modes.
- R3: In FIQ mode, R8 to R12 address a private set. Every other mode addresses a single shared set. Entering and leaving FIQ preserves both sets.
- R4: A status write whose mode field equals the current mode changes no register contents. A status write with a mode field outside the seven listed codes is ignored entirely.
- R5: Request bits are UND 0, SWI 1, PABT 2, DABT 3, IRQ 4, FIQ 5. The priority is DABT > FIQ > IRQ > PABT > UND > SWI. IRQ is not taken while I is set, and FIQ is not taken while F is set.
- R6: On entry the mode becomes UND, SVC, ABT, ABT, IRQ or FIQ for UND, SWI, PABT, DABT, IRQ and FIQ respectively. UND and SWI set I. PABT, DABT and IRQ set A and I. FIQ sets A, I and F. T is cleared and all other bits are kept.
- R7: On entry the new mode's saved status word receives the status word as it was before entry.
- R8: On entry the new mode's R14 receives the pre-entry PC plus 0 (UND, SWI), 4 (PABT, IRQ, FIQ) or 8 (DABT).
- R9: On entry the PC becomes the base plus the vector offset: 0x04 UND, 0x08 SWI, 0x0C PABT, 0x10 DABT, 0x18 IRQ, 0x1C FIQ. The base is `HI_VEC_BASE` when `hi_vec` is high and `LO_VEC_BASE` otherwise.
- R10: When an accepting edge is followed by three more edges, `busy` is high for the three cycles between them. After the third edge, `entry_done` is high for exactly one cycle, `busy` is low and PC already holds the vector.
- R11: Register and status writes are dropped while `busy` is high and in the cycle that an exception is accepted.
- R12: In USR and SYS mode the saved status output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_req | input | 6 | Level exception requests, one bit per kind |
| hi_vec | input | 1 | Selects the high vector base |
| rd_addr | input | 4 | Register read index in the current mode |
| rd_data | output | 32 | Register read data |
| reg_we | input | 1 | Register write enable |
| reg_wa | input | 4 | Register write index in the current mode |
| reg_wd | input | 32 | Register write data |
| psr_we | input | 1 | Status word write enable |
| psr_wd | input | 32 | Status word write data |
| cpsr | output | 32 | Current status word |
| spsr | output | 32 | Saved status word of the current mode |
| pc | output | 32 | Program counter (R15) |
| busy | output | 1 | Entry sequence in progress |
| entry_done | output | 1 | One-cycle pulse when the vector PC is valid |

## Verification
The bench keeps `HI_VEC_BASE` at 0xFFFF0000 and overrides `LO_VEC_BASE` to 0x00000100. With a non-zero low base, a design that ignores the base or merges it wrongly gives a visibly wrong vector on both settings of `hi_vec`. Random status writes sweep every mode and random settings of I, F and T, so masked and unmasked IRQ/FIQ, entries from USR/SYS into each bank, and FIQ-to-FIQ re-entry all occur. Directed cases cover simultaneous requests, same-mode and invalid-mode status writes, and writes attempted in the accepting and busy cycles.

// File: rtl/exc_bank_pkg.sv
`timescale 1ns/1ps
package exc_bank_pkg;
    localparam int WORD_W = 32;
    localparam int NBANK  = 6;
    localparam int BANK_W = $clog2(NBANK);
    localparam int NLOW   = 8;
    localparam int NHIGH  = 5;

    localparam logic [4:0] M_USR = 5'h10;
    localparam logic [4:0] M_FIQ = 5'h11;
    localparam logic [4:0] M_IRQ = 5'h12;
    localparam logic [4:0] M_SVC = 5'h13;
    localparam logic [4:0] M_ABT = 5'h17;
    localparam logic [4:0] M_UND = 5'h1B;
    localparam logic [4:0] M_SYS = 5'h1F;

    localparam int PSR_T = 5;
    localparam int PSR_F = 6;
    localparam int PSR_I = 7;
    localparam int PSR_A = 8;

    localparam logic [BANK_W-1:0] B_SHARED = 0;
    localparam logic [BANK_W-1:0] B_FIQ    = 5;

    typedef enum logic [2:0] {
        K_UND  = 3'd0,
        K_SWI  = 3'd1,
        K_PABT = 3'd2,
        K_DABT = 3'd3,
        K_IRQ  = 3'd4,
        K_FIQ  = 3'd5
    } kind_e;

    localparam int NKIND = 6;

    function automatic logic mode_ok(input logic [4:0] m);
        return (m == M_USR) || (m == M_FIQ) || (m == M_IRQ) || (m == M_SVC) ||
               (m == M_ABT) || (m == M_UND) || (m == M_SYS);
    endfunction

    function automatic logic [BANK_W-1:0] bank_of(input logic [4:0] m);
        unique case (m)
            M_SVC:   return 1;
            M_ABT:   return 2;
            M_UND:   return 3;
            M_IRQ:   return 4;
            M_FIQ:   return B_FIQ;
            default: return B_SHARED;
        endcase
    endfunction

    function automatic logic [4:0] kind_mode(input kind_e k);
        unique case (k)
            K_UND:           return M_UND;
            K_SWI:           return M_SVC;
            K_PABT, K_DABT:  return M_ABT;
            K_IRQ:           return M_IRQ;
            default:         return M_FIQ;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] kind_mask(input kind_e k);
        logic [WORD_W-1:0] v;
        v = '0;
        v[PSR_I] = 1'b1;
        if (k != K_UND && k != K_SWI) v[PSR_A] = 1'b1;
        if (k == K_FIQ) v[PSR_F] = 1'b1;
        return v;
    endfunction

    function automatic logic [WORD_W-1:0] kind_vec(input kind_e k);
        unique case (k)
            K_UND:   return 32'h04;
            K_SWI:   return 32'h08;
            K_PABT:  return 32'h0C;
            K_DABT:  return 32'h10;
            K_IRQ:   return 32'h18;
            default: return 32'h1C;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] kind_link(input kind_e k);
        unique case (k)
            K_UND, K_SWI: return 32'd0;
            K_DABT:       return 32'd8;
            default:      return 32'd4;
        endcase
    endfunction
endpackage

// File: rtl/exb_regfile.sv
`timescale 1ns/1ps
module exb_regfile
    import exc_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        cur_mode,
    input  logic [3:0]        rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic              we,
    input  logic [3:0]        wa,
    input  logic [WORD_W-1:0] wd,
    input  logic              sv_we,
    input  logic [4:0]        sv_mode,
    input  logic [WORD_W-1:0] sv_wd,
    output logic [WORD_W-1:0] sv_rd,
    output logic [WORD_W-1:0] pc
);
    logic [WORD_W-1:0] low_q  [NLOW];
    logic [WORD_W-1:0] shi_q  [NHIGH];
    logic [WORD_W-1:0] fhi_q  [NHIGH];
    logic [WORD_W-1:0] sp_q   [NBANK];
    logic [WORD_W-1:0] lr_q   [NBANK];
    logic [WORD_W-1:0] sv_q   [NBANK];
    logic [WORD_W-1:0] pc_q;

    logic [BANK_W-1:0] cur_b;
    logic [BANK_W-1:0] sv_b;
    logic              in_fiq;
    logic [3:0]        w_hi;
    logic [3:0]        r_hi;

    assign cur_b  = bank_of(cur_mode);
    assign sv_b   = bank_of(sv_mode);
    assign in_fiq = (cur_b == B_FIQ);
    assign w_hi   = wa - 4'd8;
    assign r_hi   = rd_addr - 4'd8;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NLOW; i++) low_q[i] <= '0;
            for (int i = 0; i < NHIGH; i++) begin
                shi_q[i] <= '0;
                fhi_q[i] <= '0;
            end
            for (int i = 0; i < NBANK; i++) begin
                sp_q[i] <= '0;
                lr_q[i] <= '0;
                sv_q[i] <= '0;
            end
            pc_q <= '0;
        end else begin
            if (we) begin
                if (wa < 4'd8)        low_q[wa[2:0]] <= wd;
                else if (wa < 4'd13) begin
                    if (in_fiq)       fhi_q[w_hi[2:0]] <= wd;
                    else              shi_q[w_hi[2:0]] <= wd;
                end
                else if (wa == 4'd13) sp_q[cur_b] <= wd;
                else if (wa == 4'd14) lr_q[cur_b] <= wd;
                else                  pc_q <= wd;
            end
            if (sv_we) sv_q[sv_b] <= sv_wd;
        end
    end

    always_comb begin
        if (rd_addr < 4'd8)        rd_data = low_q[rd_addr[2:0]];
        else if (rd_addr < 4'd13)  rd_data = in_fiq ? fhi_q[r_hi[2:0]] : shi_q[r_hi[2:0]];
        else if (rd_addr == 4'd13) rd_data = sp_q[cur_b];
        else if (rd_addr == 4'd14) rd_data = lr_q[cur_b];
        else                       rd_data = pc_q;
    end

    assign sv_rd = (cur_b == B_SHARED) ? '0 : sv_q[cur_b];
    assign pc    = pc_q;

    // R2
    no_shared_spsr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sv_we |-> bank_of(sv_mode) != B_SHARED);

    // R12
    user_spsr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_of(cur_mode) == B_SHARED) |-> sv_rd == '0);
endmodule

// File: rtl/exb_arbiter.sv
`timescale 1ns/1ps
module exb_arbiter
    import exc_bank_pkg::*;
(
    input  logic [NKIND-1:0] req,
    input  logic             i_masked,
    input  logic             f_masked,
    output logic             take,
    output kind_e            kind
);
    localparam kind_e ORDER [NKIND] = '{K_SWI, K_UND, K_PABT, K_IRQ, K_FIQ, K_DABT};

    logic [NKIND-1:0] elig;

    for (genvar g = 0; g < NKIND; g++) begin : g_elig
        if (g == int'(K_IRQ)) begin : g_irq
            assign elig[g] = req[g] & ~i_masked;
        end else if (g == int'(K_FIQ)) begin : g_fiq
            assign elig[g] = req[g] & ~f_masked;
        end else begin : g_plain
            assign elig[g] = req[g];
        end
    end

    always_comb begin
        take = 1'b0;
        kind = K_UND;
        for (int i = 0; i < NKIND; i++) begin
            if (elig[ORDER[i]]) begin
                take = 1'b1;
                kind = ORDER[i];
            end
        end
    end

    // R5
    masked_irq_chk: assert final (!(take && kind == K_IRQ && i_masked));
    // R5
    masked_fiq_chk: assert final (!(take && kind == K_FIQ && f_masked));
    // R5
    dabt_first_chk: assert final (!(req[K_DABT] && (!take || kind != K_DABT)));
endmodule

// File: rtl/exb_entry_fsm.sv
`timescale 1ns/1ps
module exb_entry_fsm
    import exc_bank_pkg::*;
#(
    parameter logic [WORD_W-1:0] HI_VEC_BASE = 32'hFFFF_0000,
    parameter logic [WORD_W-1:0] LO_VEC_BASE = 32'h0000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  kind_e             kind_in,
    input  logic              hi_vec,
    input  logic [WORD_W-1:0] pc,
    input  logic              sw_we,
    input  logic [3:0]        sw_wa,
    input  logic [WORD_W-1:0] sw_wd,
    input  logic              psr_we,
    input  logic [WORD_W-1:0] psr_wd,
    output logic [WORD_W-1:0] cpsr,
    output logic              rf_we,
    output logic [3:0]        rf_wa,
    output logic [WORD_W-1:0] rf_wd,
    output logic              sv_we,
    output logic [4:0]        sv_mode,
    output logic [WORD_W-1:0] sv_wd,
    output logic              busy,
    output logic              entry_done
);
    typedef enum logic [1:0] {S_IDLE, S_BANK, S_LINK, S_VEC} state_e;

    localparam logic [WORD_W-1:0] RESET_PSR =
        WORD_W'(M_SVC) | (WORD_W'(1) << PSR_A) | (WORD_W'(1) << PSR_I) | (WORD_W'(1) << PSR_F);
    localparam logic [WORD_W-1:0] MODE_T_BITS = WORD_W'(6'h3F);

    state_e            state_q, state_d;
    kind_e             kind_q;
    logic [WORD_W-1:0] cpsr_q;
    logic              done_q;
    logic              accept;

    assign accept = (state_q == S_IDLE) && take;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (take) state_d = S_BANK;
            S_BANK: state_d = S_LINK;
            S_LINK: state_d = S_VEC;
            S_VEC:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= K_UND;
            cpsr_q <= RESET_PSR;
            done_q <= 1'b0;
        end else begin
            done_q <= (state_q == S_VEC);
            if (accept) kind_q <= kind_in;
            if (state_q == S_BANK)
                cpsr_q <= (cpsr_q & ~MODE_T_BITS) | WORD_W'(kind_mode(kind_q)) | kind_mask(kind_q);
            else if (state_q == S_IDLE && !take && psr_we && mode_ok(psr_wd[4:0]))
                cpsr_q <= psr_wd;
        end
    end

    always_comb begin
        rf_we   = 1'b0;
        rf_wa   = sw_wa;
        rf_wd   = sw_wd;
        sv_we   = 1'b0;
        sv_mode = kind_mode(kind_q);
        sv_wd   = cpsr_q;
        unique case (state_q)
            S_IDLE: rf_we = sw_we && !take;
            S_BANK: sv_we = 1'b1;
            S_LINK: begin
                rf_we = 1'b1;
                rf_wa = 4'd14;
                rf_wd = pc + kind_link(kind_q);
            end
            S_VEC: begin
                rf_we = 1'b1;
                rf_wa = 4'd15;
                rf_wd = (hi_vec ? HI_VEC_BASE : LO_VEC_BASE) + kind_vec(kind_q);
            end
        endcase
    end

    assign cpsr       = cpsr_q;
    assign busy       = (state_q != S_IDLE);
    assign entry_done = done_q;

    // R10
    bank_then_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_BANK |=> state_q == S_LINK);
    // R10
    link_then_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_LINK |=> state_q == S_VEC);
    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_done |=> !entry_done);
    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_done |-> !busy);
    // R6
    arm_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_done |-> !cpsr[PSR_T]);
    // R6
    fiq_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LINK && kind_q == K_FIQ) |-> cpsr[PSR_F] && cpsr[PSR_I] && cpsr[PSR_A]);
    // R11
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LINK) |-> rf_wa == 4'd14);
    // R2
    mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_ok(cpsr[4:0]));
endmodule

// File: rtl/exc_bank_top.sv
`timescale 1ns/1ps
module exc_bank_top #(
    parameter logic [31:0] HI_VEC_BASE = 32'hFFFF_0000,
    parameter logic [31:0] LO_VEC_BASE = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [5:0]  exc_req,
    input  logic        hi_vec,
    input  logic [3:0]  rd_addr,
    output logic [31:0] rd_data,
    input  logic        reg_we,
    input  logic [3:0]  reg_wa,
    input  logic [31:0] reg_wd,
    input  logic        psr_we,
    input  logic [31:0] psr_wd,
    output logic [31:0] cpsr,
    output logic [31:0] spsr,
    output logic [31:0] pc,
    output logic        busy,
    output logic        entry_done
);
    import exc_bank_pkg::*;

    logic        take;
    kind_e       kind;
    logic        rf_we;
    logic [3:0]  rf_wa;
    logic [31:0] rf_wd;
    logic        sv_we;
    logic [4:0]  sv_mode;
    logic [31:0] sv_wd;

    exb_arbiter u_arb (
        .req      (exc_req),
        .i_masked (cpsr[PSR_I]),
        .f_masked (cpsr[PSR_F]),
        .take     (take),
        .kind     (kind)
    );

    exb_entry_fsm #(
        .HI_VEC_BASE (HI_VEC_BASE),
        .LO_VEC_BASE (LO_VEC_BASE)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take),
        .kind_in    (kind),
        .hi_vec     (hi_vec),
        .pc         (pc),
        .sw_we      (reg_we),
        .sw_wa      (reg_wa),
        .sw_wd      (reg_wd),
        .psr_we     (psr_we),
        .psr_wd     (psr_wd),
        .cpsr       (cpsr),
        .rf_we      (rf_we),
        .rf_wa      (rf_wa),
        .rf_wd      (rf_wd),
        .sv_we      (sv_we),
        .sv_mode    (sv_mode),
        .sv_wd      (sv_wd),
        .busy       (busy),
        .entry_done (entry_done)
    );

    exb_regfile u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .cur_mode (cpsr[4:0]),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .we       (rf_we),
        .wa       (rf_wa),
        .wd       (rf_wd),
        .sv_we    (sv_we),
        .sv_mode  (sv_mode),
        .sv_wd    (sv_wd),
        .sv_rd    (spsr),
        .pc       (pc)
    );
endmodule

// File: tb/exc_bank_top_tb.sv
`timescale 1ns/1ps
module exc_bank_top_tb;
    localparam logic [31:0] HI_B = 32'hFFFF_0000;
    localparam logic [31:0] LO_B = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  exc_req = '0;
    logic        hi_vec = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_wa = '0;
    logic [31:0] reg_wd = '0;
    logic        psr_we = 1'b0;
    logic [31:0] psr_wd = '0;
    logic [31:0] cpsr, spsr, pc;
    logic        busy, entry_done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    exc_bank_top #(.HI_VEC_BASE(HI_B), .LO_VEC_BASE(LO_B)) u_dut (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .hi_vec(hi_vec),
        .rd_addr(rd_addr), .rd_data(rd_data), .reg_we(reg_we), .reg_wa(reg_wa),
        .reg_wd(reg_wd), .psr_we(psr_we), .psr_wd(psr_wd), .cpsr(cpsr),
        .spsr(spsr), .pc(pc), .busy(busy), .entry_done(entry_done)
    );

    // reference model state
    logic [31:0] m_low [8];
    logic [31:0] m_shi [5];
    logic [31:0] m_fhi [5];
    logic [31:0] m_sp [6];
    logic [31:0] m_lr [6];
    logic [31:0] m_sv [6];
    logic [31:0] m_pc;
    logic [31:0] m_cpsr;

    function automatic int bidx(input logic [4:0] m);
        case (m)
            5'h13: return 1;
            5'h17: return 2;
            5'h1B: return 3;
            5'h12: return 4;
            5'h11: return 5;
            default: return 0;
        endcase
    endfunction

    function automatic bit legal(input logic [4:0] m);
        return m == 5'h10 || m == 5'h11 || m == 5'h12 || m == 5'h13 ||
               m == 5'h17 || m == 5'h1B || m == 5'h1F;
    endfunction

    function automatic logic [31:0] exp_reg(input int a);
        int b;
        b = bidx(m_cpsr[4:0]);
        if (a < 8) return m_low[a];
        if (a < 13) return (b == 5) ? m_fhi[a-8] : m_shi[a-8];
        if (a == 13) return m_sp[b];
        if (a == 14) return m_lr[b];
        return m_pc;
    endfunction

    function automatic logic [31:0] exp_spsr();
        int b;
        b = bidx(m_cpsr[4:0]);
        return (b == 0) ? 32'h0 : m_sv[b];
    endfunction

    // -1 when nothing is taken
    function automatic int pick(input logic [5:0] r);
        if (r[3]) return 3;
        if (r[5] && !m_cpsr[6]) return 5;
        if (r[4] && !m_cpsr[7]) return 4;
        if (r[2]) return 2;
        if (r[0]) return 0;
        if (r[1]) return 1;
        return -1;
    endfunction

    function automatic logic [4:0] k_mode(input int k);
        case (k)
            0: return 5'h1B;
            1: return 5'h13;
            2, 3: return 5'h17;
            4: return 5'h12;
            default: return 5'h11;
        endcase
    endfunction

    function automatic logic [31:0] k_mask(input int k);
        case (k)
            0, 1: return 32'h080;
            5: return 32'h1C0;
            default: return 32'h180;
        endcase
    endfunction

    function automatic logic [31:0] k_link(input int k);
        case (k)
            0, 1: return 32'd0;
            3: return 32'd8;
            default: return 32'd4;
        endcase
    endfunction

    function automatic logic [31:0] k_vec(input int k);
        case (k)
            0: return 32'h04;
            1: return 32'h08;
            2: return 32'h0C;
            3: return 32'h10;
            4: return 32'h18;
            default: return 32'h1C;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic model_write(input int a, input logic [31:0] v);
        int b;
        b = bidx(m_cpsr[4:0]);
        if (a < 8) m_low[a] = v;
        else if (a < 13) begin
            if (b == 5) m_fhi[a-8] = v;
            else m_shi[a-8] = v;
        end
        else if (a == 13) m_sp[b] = v;
        else if (a == 14) m_lr[b] = v;
        else m_pc = v;
    endtask

    // R2 R3 R12: every register seen through the current mode
    task automatic check_all(input string tag);
        for (int a = 0; a < 16; a++) begin
            rd_addr = 4'(a);
            #0.5;
            chk($sformatf("%s R2/R3 reg%0d", tag, a), rd_data, exp_reg(a));
        end
        chk({tag, " R7/R12 spsr"}, spsr, exp_spsr());
        chk({tag, " R6 cpsr"}, cpsr, m_cpsr);
    endtask

    task automatic wr_reg(input int a, input logic [31:0] v);
        reg_we = 1'b1; reg_wa = 4'(a); reg_wd = v;
        step();
        reg_we = 1'b0;
        model_write(a, v);
    endtask

    task automatic wr_psr(input logic [31:0] v);
        psr_we = 1'b1; psr_wd = v;
        step();
        psr_we = 1'b0;
        if (legal(v[4:0])) m_cpsr = v;
    endtask

    // request an exception; optionally attempt writes in the accept and first busy cycles
    task automatic do_exc(input logic [5:0] r, input bit hv, input bit with_wr);
        int k;
        logic [31:0] wv;
        k = pick(r);
        wv = $urandom;
        exc_req = r; hi_vec = hv;
        if (with_wr) begin reg_we = 1'b1; reg_wa = 4'd0; reg_wd = wv; end
        step();
        exc_req = '0; reg_we = 1'b0;
        if (k < 0) begin
            chk("R5 masked not taken busy", {31'd0, busy}, 32'd0);
            if (with_wr) model_write(0, wv);
        end else begin
            int nb;
            logic [31:0] old;
            chk("R10 busy after accept", {31'd0, busy}, 32'd1);
            if (with_wr) begin reg_we = 1'b1; reg_wa = 4'd1; reg_wd = ~wv; end
            step();
            reg_we = 1'b0;
            chk("R10 busy second", {31'd0, busy}, 32'd1);
            step();
            chk("R10 busy third", {31'd0, busy}, 32'd1);
            chk("R10 no early done", {31'd0, entry_done}, 32'd0);
            step();
            old = m_cpsr;
            nb = bidx(k_mode(k));
            m_sv[nb] = old;
            m_lr[nb] = m_pc + k_link(k);
            m_pc = (hv ? HI_B : LO_B) + k_vec(k);
            m_cpsr = (old & ~32'h3F) | {27'd0, k_mode(k)} | k_mask(k);
            chk($sformatf("R10 done pulse k%0d", k), {31'd0, entry_done}, 32'd1);
            chk("R10 busy low at done", {31'd0, busy}, 32'd0);
            chk($sformatf("R9 vector pc k%0d", k), pc, m_pc);
            step();
            chk("R10 done one cycle", {31'd0, entry_done}, 32'd0);
        end
        hi_vec = 1'b0;
    endtask

    localparam logic [4:0] MODES [7] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};

    initial begin
        #(5.0 * 190000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7731));
        for (int i = 0; i < 8; i++) m_low[i] = '0;
        for (int i = 0; i < 5; i++) begin m_shi[i] = '0; m_fhi[i] = '0; end
        for (int i = 0; i < 6; i++) begin m_sp[i] = '0; m_lr[i] = '0; m_sv[i] = '0; end
        m_pc = '0;
        m_cpsr = 32'h0000_01D3;
        #12;
        rst_n = 1'b1;
        step();

        // R1 reset state
        chk("R1 reset cpsr", cpsr, 32'h0000_01D3);
        chk("R1 reset pc", pc, 32'h0);
        chk("R1 reset busy", {31'd0, busy}, 32'd0);
        chk("R1 reset done", {31'd0, entry_done}, 32'd0);
        chk("R1 reset spsr", spsr, 32'h0);

        // R2 R3: fill banks from each mode
        for (int m = 0; m < 7; m++) begin
            wr_psr({27'd0, MODES[m]});
            for (int a = 8; a < 15; a++) wr_reg(a, $urandom);
        end
        for (int a = 0; a < 8; a++) wr_reg(a, $urandom);
        check_all("fill");

        // R4 same-mode write keeps registers, invalid mode ignored
        wr_psr(32'h0000_0011);
        wr_psr(32'hA000_0011);
        check_all("R4 same mode");
        wr_psr(32'h0000_0005);
        chk("R4 invalid mode ignored", cpsr, 32'hA000_0011);
        check_all("R4 invalid");

        // R5 priority with everything unmasked
        wr_psr(32'h0000_0010);
        do_exc(6'b111111, 1'b0, 1'b1);
        check_all("R5 dabt first");
        wr_psr(32'h0000_0010);
        do_exc(6'b110111, 1'b1, 1'b0);
        check_all("R5 fiq next");
        wr_psr(32'h0000_001F);
        do_exc(6'b010111, 1'b0, 1'b0);
        check_all("R5 irq next");
        wr_psr(32'h0000_0010);
        do_exc(6'b000101, 1'b1, 1'b0);
        check_all("R5 pabt over und");
        do_exc(6'b000011, 1'b0, 1'b1);
        check_all("R5 und over swi");
        do_exc(6'b000010, 1'b1, 1'b0);
        check_all("R8 swi");
        // R5 masked IRQ and FIQ ignored, write still lands
        wr_psr(32'h0000_00D0);
        do_exc(6'b110000, 1'b0, 1'b1);
        check_all("R5 masked");
        // R6 T bit cleared on entry from a T-set state
        wr_psr(32'h0000_0030);
        do_exc(6'b100000, 1'b0, 1'b0);
        check_all("R6 T cleared");

        // random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 4) wr_reg($urandom_range(0, 15), $urandom);
            else if (op < 6) begin
                logic [31:0] v;
                v = $urandom;
                v[4:0] = ($urandom_range(0, 9) == 0) ? 5'h0A : MODES[$urandom_range(0, 6)];
                v[8:6] = ($urandom_range(0, 1) == 0) ? 3'b000 : 3'($urandom);
                wr_psr(v);
            end else begin
                do_exc(6'($urandom), 1'($urandom), 1'($urandom));
            end
            if (it % 4 == 3) check_all("rand R2 R3");
        end
        check_all("final");

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule